// File: doc/BRIEF.md
# Supply-Monitor Reset Pulse Generator

This block turns a digital undervoltage flag into an active-low processor reset. The flag comes from an external comparator and is high while the monitored supply sits above its trip level. It is asynchronous to the block clock, so it is first passed through a two-stage synchronizer. After power-on the reset output is held low. It is released only once the synchronized flag has stayed high, without a break, for a programmable number of clock ticks.

While the reset is released, a qualification filter watches for dips. A low flag that lasts fewer ticks than the programmed qualification length is ignored. A dip that reaches that length pulls the reset low again. The reset then follows the same release rule as at power-on. So every qualifying dip produces at least one full reset period, even if the supply recovers at once. Any return of the flag to low while the reset is held restarts the period. The output is taken straight from a flip-flop, so it cannot glitch.

The hold length is sized in ticks. A 200 ms nominal period at the chosen clock rate sets the default counter width.

Top module: `supply_reset_pulser`

## Requirements
- R1: Asserting `arst_n` low forces `cpu_rst_n_o` low at once, without waiting for a clock edge. After reset is released, `cpu_rst_n_o` stays low while `supply_ok_i` is low.
- R2: In the hold state, `cpu_rst_n_o` rises at the (2 + H)-th rising clock edge after `supply_ok_i` rises, where H is `hold_len_i`. This counts 2 edges of synchronizer delay plus H counted ticks. It is low up to and including the edge before.
- R3: After release, a low pulse on `supply_ok_i` lasting fewer than Q clock cycles leaves `cpu_rst_n_o` high. Q is `qual_len_i`.
- R4: The dip filter clears as soon as the flag returns high. Two sub-Q dips separated by a single high cycle leave `cpu_rst_n_o` high.
- R5: A low pulse of at least Q cycles drives `cpu_rst_n_o` low at the (2 + Q)-th rising edge after the flag fell. The output then stays low for at least H cycles, even if the flag returned high right after Q cycles.
- R6: While the reset is held and `supply_ok_i` stays low, `cpu_rst_n_o` stays low for any length of time.
- R7: A low cycle on the synchronized flag during the hold state restarts the period count from zero. Release then comes 2 + H edges after the last rise of `supply_ok_i`.
- R8: A value of 0 in `qual_len_i` or in `hold_len_i` behaves exactly like the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low, released synchronously inside |
| supply_ok_i | input | 1 | Comparator flag, high while the supply is above its trip level; asynchronous |
| qual_len_i | input | QW | Dip qualification length in clock ticks (0 treated as 1), held steady during operation |
| hold_len_i | input | PW | Reset period length in clock ticks (0 treated as 1), held steady during operation |
| cpu_rst_n_o | output | 1 | Registered active-low processor reset |

## Verification
The bench sweeps every pairing of qualification length 0..5 and hold length 0..6, applying several flag patterns to each pairing:
- A clean power-up rise shows the exact release edge, so a period that is one tick short or long stands out.
- Dips of Q-1 cycles, alone and as two dips separated by one high cycle, show whether the filter ignores short dips and whether it clears between them.
- A dip of exactly Q cycles followed by an immediate recovery pins the trip edge, and shows that a full period follows.
- A long dip with a short high glitch during the hold separates a period counter that restarts from one that merely pauses.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_state_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dip_filter.sv
module dip_filter #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ok_i,
  input  logic [QW-1:0] len_i,
  output logic          trip_o
);

  logic [QW-1:0] len_eff;
  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_d;
  logic          at_limit;

  assign len_eff  = (len_i == '0) ? QW'(1) : len_i;
  assign at_limit = (cnt_q == len_eff - QW'(1));
  assign trip_o   = en_i && !ok_i && at_limit;

  always_comb begin
    if (!en_i || ok_i || at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: the dip counter never reaches the qualification length
  p_dip_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_eff);

  // R4: a high flag wipes any partial dip count
  p_dip_clear_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ok_i |=> (cnt_q == '0));

endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int PW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ok_i,
  input  logic [PW-1:0] len_i,
  output logic          done_o
);

  logic [PW-1:0] len_eff;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          at_limit;

  assign len_eff  = (len_i == '0) ? PW'(1) : len_i;
  assign at_limit = (cnt_q == len_eff - PW'(1));
  assign done_o   = en_i && ok_i && at_limit;

  always_comb begin
    if (!en_i || !ok_i || at_limit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: the count stays inside the programmed period
  p_period_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_eff);

  // R7: a low flag during the hold restarts the period
  p_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !ok_i) |=> (cnt_q == '0));

endmodule

// File: rtl/supply_reset_pulser.sv
module supply_reset_pulser
  import supply_reset_pkg::*;
#(
  parameter int QW = 16,
  parameter int PW = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          supply_ok_i,
  input  logic [QW-1:0] qual_len_i,
  input  logic [PW-1:0] hold_len_i,
  output logic          cpu_rst_n_o
);

  logic       core_rst_n;
  logic       ok_s;
  logic       trip;
  logic       done;
  logic       in_hold;
  logic       in_run;
  sup_state_e state_q;
  sup_state_e state_d;
  logic       rst_q;
  logic       rst_d;

  // reset: asserted asynchronously, released on a clock edge
  sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d_i   (1'b1),
    .q_o   (core_rst_n)
  );

  // comparator flag synchronizer; resets to "supply low"
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   (supply_ok_i),
    .q_o   (ok_s)
  );

  assign in_hold = (state_q == ST_HOLD);
  assign in_run  = (state_q == ST_RUN);

  dip_filter #(.QW(QW)) u_dip (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .en_i   (in_run),
    .ok_i   (ok_s),
    .len_i  (qual_len_i),
    .trip_o (trip)
  );

  period_timer #(.PW(PW)) u_period (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .en_i   (in_hold),
    .ok_i   (ok_s),
    .len_i  (hold_len_i),
    .done_o (done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD: if (done) state_d = ST_RUN;
      ST_RUN:  if (trip) state_d = ST_HOLD;
      default: state_d = ST_HOLD;
    endcase
  end

  assign rst_d = (state_d == ST_RUN);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_HOLD;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  assign cpu_rst_n_o = rst_q;

  // R6: held reset with the supply still low stays held
  p_hold_low_r6 : assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_hold && !ok_s) |=> !cpu_rst_n_o);

  // R2: release only follows a cycle with the supply good
  p_release_ok_r2 : assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(cpu_rst_n_o) |-> $past(ok_s));

  // R5: a new reset only follows a cycle with the supply low
  p_trip_low_r5 : assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(cpu_rst_n_o) |-> !$past(ok_s));

  // R1: reset input forces the output low
  p_async_r1 : assert property (@(posedge clk)
    !core_rst_n |-> !cpu_rst_n_o);

endmodule

// File: tb/supply_reset_pulser_tb.sv
module supply_reset_pulser_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QW = 4;
  localparam int PW = 5;

  logic          clk;
  logic          arst_n;
  logic          supply_ok;
  logic [QW-1:0] qual_len;
  logic [PW-1:0] hold_len;
  logic          rst_n_out;

  int total;
  int bad;

  supply_reset_pulser #(.QW(QW), .PW(PW)) dut_i (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_ok_i (supply_ok),
    .qual_len_i  (qual_len),
    .hold_len_i  (hold_len),
    .cpu_rst_n_o (rst_n_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp, input int q, input int h);
    total++;
    if (rst_n_out !== exp) begin
      bad++;
      $display("FAIL %s q=%0d h=%0d actual=%b expected=%b time=%0t",
               req, q, h, rst_n_out, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    total = 0;
    bad = 0;
    arst_n = 1'b0;
    supply_ok = 1'b0;
    qual_len = '0;
    hold_len = '0;
    step(3);
    for (int q = 0; q <= 5; q++) begin
      for (int h = 0; h <= 6; h++) begin
        int qe;
        int he;
        qe = (q == 0) ? 1 : q;  // R8: zero acts as one
        he = (h == 0) ? 1 : h;
        // R1: asynchronous reset forces low mid-cycle
        supply_ok = 1'b1;
        #1 arst_n = 1'b0;
        #1 check("R1 async", 1'b0, q, h);
        supply_ok = 1'b0;
        qual_len = QW'(q);
        hold_len = PW'(h);
        step(2);
        arst_n = 1'b1;
        step(6);
        check("R1 low after reset", 1'b0, q, h);

        // R2: release exactly 2+H edges after the rise
        supply_ok = 1'b1;
        step(he + 1);
        check("R2 before release", 1'b0, q, h);
        step(1);
        check("R2 release edge", 1'b1, q, h);
        step(3);

        // R3: short dip ignored
        if (qe > 1) begin
          supply_ok = 1'b0;
          step(qe - 1);
          supply_ok = 1'b1;
          for (int k = 0; k < qe + 3; k++) begin
            step(1);
            check("R3 short dip", 1'b1, q, h);
          end
          // R4: two short dips split by one high cycle
          supply_ok = 1'b0;
          step(qe - 1);
          supply_ok = 1'b1;
          step(1);
          supply_ok = 1'b0;
          step(qe - 1);
          supply_ok = 1'b1;
          for (int k = 0; k < qe + 3; k++) begin
            step(1);
            check("R4 filter clear", 1'b1, q, h);
          end
        end

        // R5: dip of exactly Q trips at edge 2+Q, then full period
        supply_ok = 1'b0;
        step(qe);
        supply_ok = 1'b1;
        step(1);
        check("R5 before trip", 1'b1, q, h);
        step(1);
        check("R5 trip edge", 1'b0, q, h);
        if (he > 1) begin
          step(he - 1);
          check("R5 full period", 1'b0, q, h);
        end
        step(1);
        check("R5 release after period", 1'b1, q, h);
        step(2);

        // R6: long dip holds reset as long as it lasts
        supply_ok = 1'b0;
        step(qe + 2);
        for (int k = 0; k < he + 6; k++) begin
          step(1);
          check("R6 held while low", 1'b0, q, h);
        end

        // R7: short good stretch then glitch restarts the period
        if (he > 1) begin
          supply_ok = 1'b1;
          step(he - 1);
          supply_ok = 1'b0;
          step(1);
          check("R7 no early release", 1'b0, q, h);
        end
        supply_ok = 1'b1;
        step(he + 1);
        check("R7 restart before release", 1'b0, q, h);
        step(1);
        check("R7 restart release", 1'b1, q, h);
        step(2);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule